// File: doc/BRIEF.md
# Decode-Stage Register File with Same-Cycle Write Forwarding

This block holds the general-purpose registers of a five-stage in-order pipeline. Decode reads two source operands combinationally. Writeback commits one result on the rising clock edge. Because decode and writeback can work on the same cycle, a read whose index equals the index being written gets the value that is arriving, not the stored one. This looks the same as a write completed in the first half of the cycle and a read in the second half.

Entry zero is hard-wired to zero. Writes aimed at it are dropped, and it never takes part in forwarding. The ports are plain control and data pins with no handshake. The pipeline delivers a read index every cycle and expects the operand in that same cycle, so there is no back-pressure to express. A synchronous reset clears every entry.

Top module: `gpr_file`

## Requirements
- R1: The file holds NREGS (default 8) entries of XLEN (default 32) bits, addressed by a log2(NREGS)-bit index.
- R2: After a synchronous reset (rst high on a rising edge), every entry reads zero.
- R3: When wr_en is high and wr_idx is nonzero on a rising edge, entry wr_idx takes wr_data and keeps it until written again.
- R4: Entry 0 reads as zero on both ports at all times.
- R5: A write aimed at entry 0 is dropped: entry 0 still reads zero after it, and no other entry changes.
- R6: Read ports A and B return the stored contents of entries sel_a and sel_b combinationally, in the same cycle.
- R7: When wr_en is high, wr_idx is nonzero and equals a read index, that port returns wr_data in the same cycle.
- R8: Both ports forward at the same time when both read indices equal a nonzero wr_idx with wr_en high.
- R9: With wr_en low, a matching read index still returns the stored value, and no entry changes on the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all entries |
| sel_a | input | IDXW | Read index for port A |
| sel_b | input | IDXW | Read index for port B |
| wr_en | input | 1 | Write enable from writeback |
| wr_idx | input | IDXW | Destination index of the write |
| wr_data | input | XLEN | Data being written |
| opnd_a | output | XLEN | Read data for port A |
| opnd_b | output | XLEN | Read data for port B |

## Verification
The bench first writes a distinct value, derived arithmetically from the index, into every entry. It then sweeps every pair of read indices against every write index, with the enable both high and low. This separates forwarded data from stored data, and it checks port A and port B on their own as well as together.

Writes aimed at index zero come with data that is not zero. The value read back after each such write shows whether a forwarding or storage path wrongly lets entry zero through. Reads repeated after each edge show that a write committed only to its own entry and only while the enable was high.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DEF_NREGS = 8;
  localparam int unsigned DEF_XLEN  = 32;
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_STORED = 2'd1,
    SRC_FWD    = 2'd2
  } rd_src_e;
endpackage

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned IDXW = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [XLEN-1:0]       wr_data,
  output logic [NREGS*XLEN-1:0] flat_q
);
  // Entry 0 is a constant; entries 1..NREGS-1 are flops.
  assign flat_q[XLEN-1:0] = '0;
  for (genvar g = 1; g < NREGS; g++) begin : g_ent
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_en && (wr_idx == IDXW'(g)))
        q <= wr_data;
    end
    assign flat_q[g*XLEN +: XLEN] = q;
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int unsigned NREGS = 8,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned IDXW = $clog2(NREGS)
) (
  input  logic [IDXW-1:0]       sel,
  input  logic [NREGS*XLEN-1:0] flat_q,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [XLEN-1:0]       wr_data,
  output logic [XLEN-1:0]       rdata
);
  rd_src_e src;
  always_comb begin
    if (sel == '0)
      src = SRC_ZERO;
    else if (wr_en && (wr_idx == sel))
      src = SRC_FWD;
    else
      src = SRC_STORED;
  end
  always_comb begin
    unique case (src)
      SRC_ZERO: rdata = '0;
      SRC_FWD:  rdata = wr_data;
      default:  rdata = flat_q[sel*XLEN +: XLEN];
    endcase
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned NREGS = gpr_pkg::DEF_NREGS,
  parameter int unsigned XLEN  = gpr_pkg::DEF_XLEN,
  localparam int unsigned IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] sel_a,
  input  logic [IDXW-1:0] sel_b,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b
);
  logic [NREGS*XLEN-1:0] flat_q;

  gpr_storage #(.NREGS(NREGS), .XLEN(XLEN)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .flat_q(flat_q)
  );

  logic [1:0][IDXW-1:0] sels;
  logic [1:0][XLEN-1:0] outs;
  assign sels[0] = sel_a;
  assign sels[1] = sel_b;

  for (genvar p = 0; p < 2; p++) begin : g_port
    gpr_read_port #(.NREGS(NREGS), .XLEN(XLEN)) u_rp (
      .sel(sels[p]), .flat_q(flat_q), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rdata(outs[p])
    );
  end

  assign opnd_a = outs[0];
  assign opnd_b = outs[1];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned IDXW = $clog2(NREGS)
) (
  input logic            clk,
  input logic            rst,
  input logic [IDXW-1:0] sel_a,
  input logic [IDXW-1:0] sel_b,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b
);
  AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (sel_a == '0) |-> (opnd_a == '0)); // R4
  AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (sel_b == '0) |-> (opnd_b == '0)); // R4
  AST_FWD_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && sel_a == wr_idx) |-> (opnd_a == wr_data)); // R7
  AST_FWD_B: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && sel_b == wr_idx) |-> (opnd_b == wr_data)); // R7
  AST_FWD_BOTH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && sel_a == wr_idx && sel_b == wr_idx)
      |-> (opnd_a == opnd_b)); // R8
  AST_COMMIT_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && sel_a == wr_idx)
      |=> ((sel_a != $past(wr_idx)) || (wr_en && wr_idx == sel_a)
           || (opnd_a == $past(wr_data)))); // R3
  AST_RESET_CLR: assert property (@(posedge clk)
    $past(rst) && !rst && !wr_en |-> (opnd_a == '0 && opnd_b == '0)); // R2
endmodule

bind gpr_file gpr_file_chk #(.NREGS(NREGS), .XLEN(XLEN)) u_chk (.*);

// File: tb/gpr_file_test.sv
`timescale 1ns/1ps
module gpr_file_test;
  localparam int unsigned NREGS = 8;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IDXW  = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IDXW-1:0] sel_a = '0, sel_b = '0, wr_idx = '0;
  logic wr_en = 1'b0;
  logic [XLEN-1:0] wr_data = '0;
  logic [XLEN-1:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  logic [XLEN-1:0] model [NREGS];

  always #2.5 clk = ~clk;

  gpr_file #(.NREGS(NREGS), .XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [XLEN-1:0] pat(int i, int salt);
    return XLEN'(32'h1357_0000 + i * 32'h0101_0011 + salt * 32'h0003_0507);
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change on negedge; outputs are sampled just before the next posedge.
  task automatic drive(logic e, int wi, logic [XLEN-1:0] d, int a, int b);
    @(negedge clk);
    wr_en = e; wr_idx = IDXW'(wi); wr_data = d; sel_a = IDXW'(a); sel_b = IDXW'(b);
    #1;
  endtask

  task automatic commit();
    if (wr_en && wr_idx != '0) model[wr_idx] = wr_data;
    @(posedge clk); #0.1;
  endtask

  function automatic logic [XLEN-1:0] expect_rd(int s);
    if (s == 0) return '0;
    if (wr_en && int'(wr_idx) == s) return wr_data;
    return model[s];
  endfunction

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R2: reset state across all entries
    for (int i = 0; i < NREGS; i++) begin
      drive(1'b0, 0, '0, i, NREGS-1-i);
      chk("R2 reset A", opnd_a, '0);
      chk("R2 reset B", opnd_b, '0);
    end
    // R1/R3: fill every entry with an index-derived value, including index 0
    for (int i = 0; i < NREGS; i++) begin
      drive(1'b1, i, pat(i, 0), 0, 0);
      commit();
    end
    for (int i = 0; i < NREGS; i++) begin
      drive(1'b0, 0, '0, i, i);
      chk("R1 R3 R6 stored A", opnd_a, expect_rd(i));
      chk("R6 stored B", opnd_b, expect_rd(i));
    end
    // Sweep: every write index x enable x port pair (R4 R5 R7 R8 R9)
    for (int w = 0; w < NREGS; w++) begin
      for (int e = 0; e < 2; e++) begin
        for (int a = 0; a < NREGS; a++) begin
          for (int b = 0; b < NREGS; b++) begin
            logic [XLEN-1:0] d;
            d = pat(w, 1 + e + a * NREGS + b) | XLEN'(1);
            drive(e[0], w, d, a, b);
            if (a == 0) chk("R4 zero A", opnd_a, '0);
            else if (e == 1 && a == w) chk("R7 fwd A", opnd_a, d);
            else if (e == 0) chk("R9 no-en A", opnd_a, model[a]);
            else chk("R6 A", opnd_a, expect_rd(a));
            if (e == 1 && a == w && b == w && w != 0) chk("R8 both B", opnd_b, d);
            else chk("R7 B", opnd_b, expect_rd(b));
            commit();
          end
        end
        // After each group: readback of all entries (R5 R9 R3)
        for (int i = 0; i < NREGS; i++) begin
          drive(1'b0, 0, '0, i, 0);
          chk(w == 0 ? "R5 after x0 write" : (e == 0 ? "R9 hold" : "R3 hold"),
              opnd_a, expect_rd(i));
          chk("R4 zero B", opnd_b, '0);
        end
      end
    end
    // R2: reset again after data is present
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    @(posedge clk); #0.1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    for (int i = 0; i < NREGS; i++) begin
      drive(1'b0, 0, '0, i, i);
      chk("R2 reclear", opnd_a, '0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule